// File: doc/BRIEF.md
# Cache-Line Write Gathering Unit

This unit sits between a local-bus write port and the master side of a PCI interface. When write-and-invalidate operation is enabled and correctly configured, it collects eight 32-bit words from the local writer into a line buffer. It withholds any request toward PCI until the whole line is held. It then sends the line as one unbroken burst tagged with the memory-write-and-invalidate command (0xF). That command is only legal when a full cache line is written in a single bus ownership.

When the mode is off, each local write is forwarded at once as a single-beat transfer carrying the programmed command code. When the mode is on but the line-size setting is not eight words or the command code is not 0xF, the unit raises a configuration error flag. It then falls back to single-beat plain memory writes (command 0x7). A line must start on a 32-byte boundary. A misaligned first word raises an alignment error pulse and is sent alone as a plain memory write.

The output side uses a valid/ready handshake. `ob_valid` held high across the beats of a burst represents keeping bus ownership. Arbitration itself is left to the surrounding logic.

Top module: `wig_line_gather`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ob_valid`, `cfg_err` and `err_align` are 0 and `lw_ready` is 1.
- R2: In gathering mode (`cfg_wi_en`=1, `cfg_line_size`=8, `cfg_cmd`=0xF), `ob_valid` stays 0 while fewer than 8 words have been accepted. It rises in the cycle after the 8th word is accepted.
- R3: A gathered line is sent as 8 beats with command 0xF. Beat k carries the k-th accepted word and the address line base + 4·k. `ob_last` is 1 on beat 7 only.
- R4: From the first beat of a line until its last beat is accepted, `ob_valid` stays 1 every cycle. While `ob_ready` is 0, the presented beat (address, data, command, last) holds steady.
- R5: `lw_ready` is 0 from the cycle after the 8th word is accepted until the last beat is accepted, and returns to 1 in the following cycle.
- R6: With `cfg_wi_en`=0, each accepted write leaves as one beat with `ob_last`=1, the same address and data, and command equal to `cfg_cmd`. `cfg_err` stays 0.
- R7: With `cfg_wi_en`=1 and either `cfg_line_size`≠8 or `cfg_cmd`≠0xF, `cfg_err` is 1 one cycle after that setting is applied. Writes then leave as single beats with command 0x7.
- R8: In gathering mode, a first word whose address bits [4:0] are not zero makes `err_align` high for exactly one cycle. That word leaves alone as a single beat with command 0x7, and the next aligned write starts a fresh line.
- R9: The addresses presented with words 2 to 8 of a line are ignored. Beat addresses come only from the first word's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wi_en | input | 1 | Write-and-invalidate mode enable |
| cfg_cmd | input | 4 | Programmed direct-master command code |
| cfg_line_size | input | 8 | Cache-line-size setting in 32-bit words |
| lw_valid | input | 1 | Local write request |
| lw_addr | input | 32 | Local write byte address |
| lw_data | input | 32 | Local write data |
| lw_ready | output | 1 | Local write accepted when high with lw_valid |
| ob_valid | output | 1 | Outbound beat valid (held across a burst) |
| ob_ready | input | 1 | Outbound beat accepted |
| ob_addr | output | 32 | Byte address of the current beat |
| ob_data | output | 32 | Data of the current beat |
| ob_cmd | output | 4 | PCI command code of the current beat |
| ob_last | output | 1 | Final beat of the transfer |
| cfg_err | output | 1 | Mode enabled with an unusable configuration |
| err_align | output | 1 | One-cycle pulse on a misaligned line start |

## Verification
The hardest situation to reach is a target stall in the middle of a gathered burst while the local writer is still pushing. That is where a release of ownership, a corrupted beat or a leaked write would show. The directed line scenario fills a line, then drops `ob_ready` for several cycles after beat 3. It checks that the beat stays frozen, `ob_valid` stays high and `lw_ready` stays low. A second line is written with junk addresses on its later words, right after a misaligned start, to reach the alignment recovery path.

// File: rtl/wig_pkg.sv
// Package: shared state encoding and PCI command codes for the
// cache-line write gathering unit.
package wig_pkg;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_BURST  = 2'd1,
        ST_SINGLE = 2'd2
    } wig_state_e;

    localparam logic [3:0] CMD_MWI = 4'hF;   // memory write and invalidate
    localparam logic [3:0] CMD_MW  = 4'h7;   // plain memory write

endpackage

// File: rtl/wig_cfg_check.sv
// Module: wig_cfg_check
// Decides whether line gathering may be used with the present settings,
// flags an unusable configuration, and chooses the command for
// single-beat writes. Assumes settings are quasi-static.
module wig_cfg_check
    import wig_pkg::*;
#(
    parameter int LSIZE_W    = 8,
    parameter int LINE_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_en,
    input  logic [3:0]         cmd,
    input  logic [LSIZE_W-1:0] line_size,
    output logic               gather_ok,
    output logic [3:0]         pass_cmd,
    output logic               cfg_err
);

    logic settings_match;

    // Settings are usable when line size and command both fit the mode
    always_comb begin
        settings_match = (line_size == LSIZE_W'(LINE_WORDS)) && (cmd == CMD_MWI);
        gather_ok      = mode_en && settings_match;
        pass_cmd       = mode_en ? CMD_MW : cmd;
    end

    // Register the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= mode_en && !settings_match;
    end

endmodule

// File: rtl/wig_line_buf.sv
// Module: wig_line_buf
// Storage for one cache line: one write port indexed by word, one
// combinational read port. Contents need no reset because the controller
// never reads a word it has not written for the current line.
module wig_line_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    // One register per word, loaded when its index is written
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g))) words[g] <= wdata;
        end
    end

    // Read port
    always_comb rdata = words[ridx];

endmodule

// File: rtl/wig_gather_fsm.sv
// Module: wig_gather_fsm
// Accepts local writes, fills the line buffer and sequences the outbound
// burst, or forwards single beats when gathering is not usable. Assumes
// LINE_WORDS is a power of two and addresses are byte addresses of
// 32-bit words.
module wig_gather_fsm
    import wig_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int OFF_W     = $clog2(LINE_WORDS * 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gather_ok,
    input  logic [3:0]        pass_cmd,
    input  logic              lw_valid,
    input  logic [ADDR_W-1:0] lw_addr,
    input  logic [DATA_W-1:0] lw_data,
    output logic              lw_ready,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_widx,
    output logic [IDX_W-1:0]  buf_ridx,
    input  logic [DATA_W-1:0] buf_rdata,
    input  logic              ob_ready,
    output logic              ob_valid,
    output logic [ADDR_W-1:0] ob_addr,
    output logic [DATA_W-1:0] ob_data,
    output logic [3:0]        ob_cmd,
    output logic              ob_last,
    output logic              err_align
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

    wig_state_e        state;
    logic [IDX_W-1:0]  wr_cnt;
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] sgl_addr;
    logic [DATA_W-1:0] sgl_data;
    logic [3:0]        sgl_cmd;
    logic              accept;
    logic              first_word;
    logic              misaligned;

    // Handshake and classification of the incoming word
    always_comb begin
        lw_ready   = (state == ST_FILL);
        accept     = lw_valid && lw_ready;
        first_word = (wr_cnt == '0);
        misaligned = |lw_addr[OFF_W-1:0];
        buf_we     = accept && (!first_word || (gather_ok && !misaligned));
        buf_widx   = wr_cnt;
        buf_ridx   = rd_idx;
    end

    // Control state, counters and single-beat holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FILL;
            wr_cnt    <= '0;
            rd_idx    <= '0;
            base_addr <= '0;
            sgl_addr  <= '0;
            sgl_data  <= '0;
            sgl_cmd   <= CMD_MW;
            err_align <= 1'b0;
        end else begin
            err_align <= 1'b0;
            unique case (state)
                ST_FILL: begin
                    if (accept) begin
                        if (first_word && !gather_ok) begin
                            sgl_addr <= lw_addr;
                            sgl_data <= lw_data;
                            sgl_cmd  <= pass_cmd;
                            state    <= ST_SINGLE;
                        end else if (first_word && misaligned) begin
                            sgl_addr  <= lw_addr;
                            sgl_data  <= lw_data;
                            sgl_cmd   <= CMD_MW;
                            err_align <= 1'b1;
                            state     <= ST_SINGLE;
                        end else begin
                            if (first_word) base_addr <= lw_addr;
                            if (wr_cnt == LAST_IDX) begin
                                wr_cnt <= '0;
                                rd_idx <= '0;
                                state  <= ST_BURST;
                            end else begin
                                wr_cnt <= wr_cnt + 1'b1;
                            end
                        end
                    end
                end
                ST_BURST: begin
                    if (ob_ready) begin
                        if (rd_idx == LAST_IDX) state  <= ST_FILL;
                        else                    rd_idx <= rd_idx + 1'b1;
                    end
                end
                ST_SINGLE: begin
                    if (ob_ready) state <= ST_FILL;
                end
                default: state <= ST_FILL;
            endcase
        end
    end

    // Outbound beat selection
    always_comb begin
        ob_valid = (state != ST_FILL);
        if (state == ST_BURST) begin
            ob_addr = base_addr | (ADDR_W'(rd_idx) << 2);
            ob_data = buf_rdata;
            ob_cmd  = CMD_MWI;
            ob_last = (rd_idx == LAST_IDX);
        end else begin
            ob_addr = sgl_addr;
            ob_data = sgl_data;
            ob_cmd  = sgl_cmd;
            ob_last = 1'b1;
        end
    end

endmodule

// File: rtl/wig_line_gather.sv
// Module: wig_line_gather (top)
// Gathers eight local writes into one write-and-invalidate burst, or
// forwards single beats when the mode is off or misconfigured. Assumes
// the downstream side keeps bus ownership while ob_valid stays high.
module wig_line_gather #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int LSIZE_W    = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wi_en,
    input  logic [3:0]         cfg_cmd,
    input  logic [LSIZE_W-1:0] cfg_line_size,
    input  logic               lw_valid,
    input  logic [ADDR_W-1:0]  lw_addr,
    input  logic [DATA_W-1:0]  lw_data,
    output logic               lw_ready,
    output logic               ob_valid,
    input  logic               ob_ready,
    output logic [ADDR_W-1:0]  ob_addr,
    output logic [DATA_W-1:0]  ob_data,
    output logic [3:0]         ob_cmd,
    output logic               ob_last,
    output logic               cfg_err,
    output logic               err_align
);

    logic              gather_ok;
    logic [3:0]        pass_cmd;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_widx;
    logic [IDX_W-1:0]  buf_ridx;
    logic [DATA_W-1:0] buf_rdata;

    wig_cfg_check #(.LSIZE_W(LSIZE_W), .LINE_WORDS(LINE_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .mode_en(cfg_wi_en), .cmd(cfg_cmd),
        .line_size(cfg_line_size), .gather_ok(gather_ok),
        .pass_cmd(pass_cmd), .cfg_err(cfg_err)
    );

    wig_line_buf #(.DATA_W(DATA_W), .DEPTH(LINE_WORDS)) u_buf (
        .clk(clk), .we(buf_we), .widx(buf_widx), .wdata(lw_data),
        .ridx(buf_ridx), .rdata(buf_rdata)
    );

    wig_gather_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .gather_ok(gather_ok), .pass_cmd(pass_cmd),
        .lw_valid(lw_valid), .lw_addr(lw_addr), .lw_data(lw_data),
        .lw_ready(lw_ready), .buf_we(buf_we), .buf_widx(buf_widx),
        .buf_ridx(buf_ridx), .buf_rdata(buf_rdata), .ob_ready(ob_ready),
        .ob_valid(ob_valid), .ob_addr(ob_addr), .ob_data(ob_data),
        .ob_cmd(ob_cmd), .ob_last(ob_last), .err_align(err_align)
    );

endmodule

// File: rtl/wig_line_gather_chk.sv
// Module: wig_line_gather_chk
// Protocol checker bound to the top module: beat stability under stall,
// burst continuity, writer backpressure and error pulse shape.
module wig_line_gather_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lw_ready,
    input logic              ob_valid,
    input logic              ob_ready,
    input logic [ADDR_W-1:0] ob_addr,
    input logic [DATA_W-1:0] ob_data,
    input logic [3:0]        ob_cmd,
    input logic              ob_last,
    input logic              cfg_err,
    input logic              err_align
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!ob_valid && lw_ready && !cfg_err && !err_align));

    // R4
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_valid && !ob_ready) |=> (ob_valid && $stable(ob_addr) && $stable(ob_data)
                                     && $stable(ob_cmd) && $stable(ob_last)));

    // R4
    burst_continuity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_valid && ob_ready && !ob_last) |=> ob_valid);

    // R5
    writer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ob_valid |-> !lw_ready);

    // R8
    align_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |=> !err_align);

endmodule

bind wig_line_gather wig_line_gather_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lw_ready(lw_ready), .ob_valid(ob_valid),
    .ob_ready(ob_ready), .ob_addr(ob_addr), .ob_data(ob_data), .ob_cmd(ob_cmd),
    .ob_last(ob_last), .cfg_err(cfg_err), .err_align(err_align)
);

// File: tb/wig_line_gather_test.sv
// Directed bench for wig_line_gather: one task per scenario.
module wig_line_gather_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wi_en = 1'b0;
    logic [3:0]  cfg_cmd = 4'h7;
    logic [7:0]  cfg_line_size = 8'd8;
    logic        lw_valid = 1'b0;
    logic [31:0] lw_addr = '0;
    logic [31:0] lw_data = '0;
    logic        lw_ready;
    logic        ob_valid;
    logic        ob_ready = 1'b0;
    logic [31:0] ob_addr;
    logic [31:0] ob_data;
    logic [3:0]  ob_cmd;
    logic        ob_last;
    logic        cfg_err;
    logic        err_align;

    int checks = 0;
    int errors = 0;

    wig_line_gather uut (
        .clk(clk), .rst_n(rst_n), .cfg_wi_en(cfg_wi_en), .cfg_cmd(cfg_cmd),
        .cfg_line_size(cfg_line_size), .lw_valid(lw_valid), .lw_addr(lw_addr),
        .lw_data(lw_data), .lw_ready(lw_ready), .ob_valid(ob_valid),
        .ob_ready(ob_ready), .ob_addr(ob_addr), .ob_data(ob_data),
        .ob_cmd(ob_cmd), .ob_last(ob_last), .cfg_err(cfg_err), .err_align(err_align)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record one check result
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one local write and wait until it is accepted
    task automatic put(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        lw_valid = 1'b1; lw_addr = a; lw_data = d;
        while (!lw_ready) @(negedge clk);
        @(posedge clk); #1;
        lw_valid = 1'b0;
    endtask

    // Accept one outbound beat and return its fields
    task automatic take(output logic [31:0] a, output logic [31:0] d,
                        output logic [3:0] c, output logic l);
        @(negedge clk);
        ob_ready = 1'b1;
        while (!ob_valid) @(negedge clk);
        a = ob_addr; d = ob_data; c = ob_cmd; l = ob_last;
        @(posedge clk); #1;
        ob_ready = 1'b0;
    endtask

    function automatic logic [31:0] pat(input logic [31:0] base, input int i);
        return {base[15:0], 16'hA500 + 16'(i)};
    endfunction

    // Scenario: reset values
    task automatic t_reset();
        @(negedge clk);
        check("R1 ob_valid", 32'(ob_valid), 0);
        check("R1 lw_ready", 32'(lw_ready), 1);
        check("R1 cfg_err", 32'(cfg_err), 0);
        check("R1 err_align", 32'(err_align), 0);
    endtask

    // Scenario: one gathered line, optional stall and junk later addresses
    task automatic t_line(input logic [31:0] base, input bit stall, input bit junk);
        logic [31:0] a, d;
        logic [3:0]  c;
        logic        l;
        for (int i = 0; i < 8; i++) begin
            put((i == 0) ? base : (junk ? 32'hBAD0_0013 + 32'(i) : base + 32'(4*i)),
                pat(base, i));
            if (i == 6) begin
                @(negedge clk);
                check("R2 no request before 8 words", 32'(ob_valid), 0);
            end
        end
        @(negedge clk);
        check("R2 request after 8th word", 32'(ob_valid), 1);
        check("R5 writer held", 32'(lw_ready), 0);
        for (int k = 0; k < 8; k++) begin
            take(a, d, c, l);
            check(junk ? "R9 beat addr" : "R3 beat addr", a, base + 32'(4*k));
            check("R3 beat data", d, pat(base, k));
            check("R3 beat cmd", 32'(c), 32'hF);
            check("R3 last flag", 32'(l), (k == 7) ? 1 : 0);
            if (stall && k == 3) begin
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check("R4 valid held in stall", 32'(ob_valid), 1);
                    check("R4 beat frozen", ob_addr, base + 32'd16);
                    check("R5 writer held in stall", 32'(lw_ready), 0);
                end
            end
        end
        @(negedge clk);
        check("R5 writer released", 32'(lw_ready), 1);
        check("R4 burst ended", 32'(ob_valid), 0);
    endtask

    // Scenario: mode disabled, single beats with programmed command
    task automatic t_disabled();
        logic [31:0] a, d;
        logic [3:0]  c;
        logic        l;
        cfg_wi_en = 1'b0; cfg_cmd = 4'hF; cfg_line_size = 8'd8;
        put(32'h0000_2004, 32'h1111_2222);
        @(negedge clk);
        check("R6 single beat pending", 32'(ob_valid), 1);
        check("R6 writer held", 32'(lw_ready), 0);
        take(a, d, c, l);
        check("R6 addr", a, 32'h0000_2004);
        check("R6 data", d, 32'h1111_2222);
        check("R6 cmd", 32'(c), 32'hF);
        check("R6 last", 32'(l), 1);
        check("R6 no cfg_err", 32'(cfg_err), 0);
    endtask

    // Scenario: enabled with bad line size or command
    task automatic t_cfg_error(input logic [7:0] lsz, input logic [3:0] cmd);
        logic [31:0] a, d;
        logic [3:0]  c;
        logic        l;
        @(negedge clk);
        cfg_wi_en = 1'b1; cfg_cmd = cmd; cfg_line_size = lsz;
        @(negedge clk);
        check("R7 cfg_err raised", 32'(cfg_err), 1);
        put(32'h0000_3000, 32'h3333_4444);
        take(a, d, c, l);
        check("R7 fallback cmd", 32'(c), 32'h7);
        check("R7 fallback last", 32'(l), 1);
        check("R7 fallback data", d, 32'h3333_4444);
    endtask

    // Scenario: misaligned line start, then recovery
    task automatic t_misaligned();
        logic [31:0] a, d;
        logic [3:0]  c;
        logic        l;
        @(negedge clk);
        cfg_wi_en = 1'b1; cfg_cmd = 4'hF; cfg_line_size = 8'd8;
        @(negedge clk);
        check("R7 cfg_err cleared", 32'(cfg_err), 0);
        put(32'h0000_1004, 32'h5555_6666);
        @(negedge clk);
        check("R8 err_align pulse", 32'(err_align), 1);
        take(a, d, c, l);
        check("R8 single addr", a, 32'h0000_1004);
        check("R8 single cmd", 32'(c), 32'h7);
        check("R8 single last", 32'(l), 1);
        @(negedge clk);
        check("R8 err_align one cycle", 32'(err_align), 0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset lw_ready", 32'(lw_ready), 1);
        check("R1 after reset ob_valid", 32'(ob_valid), 0);
        cfg_wi_en = 1'b1; cfg_cmd = 4'hF; cfg_line_size = 8'd8;
        t_line(32'h0000_4000, 1'b0, 1'b0);
        t_line(32'h0001_0060, 1'b1, 1'b0);
        t_disabled();
        t_cfg_error(8'd16, 4'hF);
        t_cfg_error(8'd8, 4'h7);
        t_misaligned();
        t_line(32'h0000_1020, 1'b0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule